// File: doc/BRIEF.md
# Board Status Indicator Monitor

This block drives the status lamps of a high-speed converter capture system from a local reference clock. It watches the two data clocks that come back from the converter and lights a clock-good lamp only while both are running. It turns short, asynchronous event pins into pulses long enough to see: calibration-running and one over-range pin per channel. It also passes on the hardware-trigger enable, the extended-control state and a supply-good flag.

A single operational lamp qualifies all the others. It lights once the reference PLL reports lock and reset has been released. While it is dark, every other lamp is held off, so a lamp that is lit is always valid. The stretch length and the clock-absence window are parameters counted in reference cycles. The default stretch is half a second at 100 MHz.

Top module: `board_status_monitor`

## Requirements
- R1: `led_oper` is high in the cycle after the second reference edge that samples `ref_lock_in` high, and it falls with the same two-edge latency when the lock is lost.
- R2: While `led_oper` is low, every other lamp output is low.
- R3: `led_dclk_ok` is high only while both data clocks toggle. It falls once a data clock has shown no edge for `WINDOW_CYCLES` reference cycles, and it rises again after that clock restarts.
- R4: A calibration pin sampled high on reference edge k makes `led_cal` high from edge k+2. A single-cycle pulse gives exactly `STRETCH_CYCLES` cycles of `led_cal`.
- R5: The two over-range lamps `led_ovr_i` and `led_ovr_q` each follow only their own pin, with the same latency and length as R4.
- R6: A new event during an active stretch reloads the full length. The lamp stays high without a gap and goes low `STRETCH_CYCLES` cycles after the last synchronized event.
- R7: `led_trig_armed` follows `hw_trig_en_in` with a two-edge latency and stays high for as long as the enable is held.
- R8: `led_ext_ctl` and `led_supply` follow their inputs with a two-edge latency.
- R9: A reference edge that samples `rst_n` low clears every lamp in the following cycle and restarts all stretches and clock-activity windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Local reference clock; all lamps are timed on it |
| rst_n | input | 1 | Synchronous active-low reset |
| data_clk_i | input | 1 | Data clock returned for the I channel |
| data_clk_q | input | 1 | Data clock returned for the Q channel |
| ref_lock_in | input | 1 | Reference PLL lock flag, asynchronous |
| cal_run_in | input | 1 | Calibration-running pin, asynchronous |
| ovr_i_in | input | 1 | I-channel over-range pin, asynchronous |
| ovr_q_in | input | 1 | Q-channel over-range pin, asynchronous |
| hw_trig_en_in | input | 1 | Hardware-trigger enable level |
| ext_ctl_in | input | 1 | Extended-control mode level |
| supply_ok_in | input | 1 | Converter supply-good level |
| led_dclk_ok | output | 1 | Both data clocks active |
| led_cal | output | 1 | Stretched calibration indication |
| led_ovr_i | output | 1 | Stretched I over-range indication |
| led_ovr_q | output | 1 | Stretched Q over-range indication |
| led_trig_armed | output | 1 | Trigger armed |
| led_ext_ctl | output | 1 | Extended control active |
| led_supply | output | 1 | Supply good |
| led_oper | output | 1 | Operational qualifier |

## Verification
Two events can fall in the same cycle: a stretch reload and the last cycle of a running stretch, and a loss of lock and the first cycle of a fresh stretch. The bench provokes the first by placing a second over-range pulse so that its reload lands on the final lit cycle. It provokes the second by dropping the lock so that the operational lamp falls while a calibration stretch is just starting. A behavioural model built on a queue of sampled pins predicts every lamp on every cycle. The two cases are judged by whether the lamp shows a gap, or stays lit while unqualified.

// File: rtl/stat_ind_pkg.sv
// Package: shared pin indices for the status indicator monitor.
// Assumes the three stretched events occupy consecutive indices from PIN_CAL.
package stat_ind_pkg;
    typedef enum int {
        PIN_LOCK  = 0,
        PIN_CAL   = 1,
        PIN_OVR_I = 2,
        PIN_OVR_Q = 3,
        PIN_TRIG  = 4,
        PIN_XCTL  = 5,
        PIN_PWR   = 6
    } pin_e;

    localparam int NUM_PINS    = 7;
    localparam int NUM_STRETCH = 3;
    localparam int NUM_DCLK    = 2;
endpackage

// File: rtl/level_sync.sv
// Module: two-stage synchronizer for a vector of independent levels.
// Assumes each bit is an unrelated asynchronous level; no bus coherence.
module level_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] meta;

    // Two flops per bit, both cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta   <= '0;
            q_sync <= '0;
        end else begin
            meta   <= d_async;
            q_sync <= meta;
        end
    end
endmodule

// File: rtl/event_stretcher.sv
// Module: retriggerable pulse stretcher.
// Assumes evt is already synchronized. While evt is high the count reloads.
module event_stretcher #(
    parameter int STRETCH_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    output logic active
);
    localparam int CW = $clog2(STRETCH_CYCLES + 1);

    logic [CW-1:0] remain;

    // Reload on every event, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (evt)
            remain <= CW'(STRETCH_CYCLES);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign active = (remain != '0);
endmodule

// File: rtl/clk_activity_detect.sv
// Module: detects a running foreign clock by watching a toggle flop from it.
// Assumes the foreign clock is slower than half the reference rate.
module clk_activity_detect #(
    parameter int WINDOW_CYCLES = 1024
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic data_clk,
    output logic alive
);
    localparam int CW = $clog2(WINDOW_CYCLES + 1);

    logic          tgl;
    logic [2:0]    chain;
    logic [CW-1:0] idle_cnt;
    logic          edge_seen;

    // Toggle once per foreign clock edge.
    always_ff @(posedge data_clk) begin
        if (!rst_n)
            tgl <= 1'b0;
        else
            tgl <= ~tgl;
    end

    // Carry the toggle into the reference domain (two sync stages plus one for edge compare).
    always_ff @(posedge clk_ref) begin
        if (!rst_n)
            chain <= '0;
        else
            chain <= {chain[1:0], tgl};
    end

    assign edge_seen = chain[2] ^ chain[1];

    // Count idle reference cycles; declare absence once the window elapses.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            alive    <= 1'b0;
        end else if (edge_seen) begin
            idle_cnt <= '0;
            alive    <= 1'b1;
        end else if (idle_cnt == CW'(WINDOW_CYCLES - 1)) begin
            alive    <= 1'b0;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/board_status_monitor.sv
// Module: status lamp driver for a dual-channel converter capture system.
// Synchronizes every level and event pin, stretches the event pins, checks both
// data clocks for activity and gates every lamp on the operational qualifier.
// Assumes all lamp timing is in clk_ref cycles and rst_n is synchronous to clk_ref.
module board_status_monitor
    import stat_ind_pkg::*;
#(
    parameter int STRETCH_CYCLES = 50_000_000,
    parameter int WINDOW_CYCLES  = 1024
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic data_clk_i,
    input  logic data_clk_q,
    input  logic ref_lock_in,
    input  logic cal_run_in,
    input  logic ovr_i_in,
    input  logic ovr_q_in,
    input  logic hw_trig_en_in,
    input  logic ext_ctl_in,
    input  logic supply_ok_in,
    output logic led_dclk_ok,
    output logic led_cal,
    output logic led_ovr_i,
    output logic led_ovr_q,
    output logic led_trig_armed,
    output logic led_ext_ctl,
    output logic led_supply,
    output logic led_oper
);
    logic [NUM_PINS-1:0]    pin_raw;
    logic [NUM_PINS-1:0]    pin_sync;
    logic [NUM_STRETCH-1:0] stretched;
    logic [NUM_DCLK-1:0]    dclk_vec;
    logic [NUM_DCLK-1:0]    dclk_alive;
    logic                   oper;

    // Gather the asynchronous pins into one vector by index.
    always_comb begin
        pin_raw            = '0;
        pin_raw[PIN_LOCK]  = ref_lock_in;
        pin_raw[PIN_CAL]   = cal_run_in;
        pin_raw[PIN_OVR_I] = ovr_i_in;
        pin_raw[PIN_OVR_Q] = ovr_q_in;
        pin_raw[PIN_TRIG]  = hw_trig_en_in;
        pin_raw[PIN_XCTL]  = ext_ctl_in;
        pin_raw[PIN_PWR]   = supply_ok_in;
    end

    level_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .d_async (pin_raw),
        .q_sync  (pin_sync)
    );

    // One stretcher per event pin.
    for (genvar gs = 0; gs < NUM_STRETCH; gs++) begin : g_stretch
        event_stretcher #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_str (
            .clk    (clk_ref),
            .rst_n  (rst_n),
            .evt    (pin_sync[int'(PIN_CAL) + gs]),
            .active (stretched[gs])
        );
    end

    assign dclk_vec = {data_clk_q, data_clk_i};

    // One activity detector per data clock.
    for (genvar gd = 0; gd < NUM_DCLK; gd++) begin : g_dclk
        clk_activity_detect #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_act (
            .clk_ref  (clk_ref),
            .rst_n    (rst_n),
            .data_clk (dclk_vec[gd]),
            .alive    (dclk_alive[gd])
        );
    end

    // The synchronized lock is the operational qualifier (reset clears it).
    assign oper = pin_sync[PIN_LOCK];

    // Qualify every lamp with the operational state.
    always_comb begin
        led_oper       = oper;
        led_dclk_ok    = oper & (&dclk_alive);
        led_cal        = oper & stretched[0];
        led_ovr_i      = oper & stretched[1];
        led_ovr_q      = oper & stretched[2];
        led_trig_armed = oper & pin_sync[PIN_TRIG];
        led_ext_ctl    = oper & pin_sync[PIN_XCTL];
        led_supply     = oper & pin_sync[PIN_PWR];
    end
endmodule

// File: rtl/board_status_monitor_sva.sv
// Module: property checker for board_status_monitor, attached by bind.
// Assumes the latencies of the two-stage synchronizers named in the brief.
module board_status_monitor_sva (
    input logic clk_ref,
    input logic rst_n,
    input logic ref_lock_in,
    input logic cal_run_in,
    input logic ovr_i_in,
    input logic ovr_q_in,
    input logic hw_trig_en_in,
    input logic led_dclk_ok,
    input logic led_cal,
    input logic led_ovr_i,
    input logic led_ovr_q,
    input logic led_trig_armed,
    input logic led_ext_ctl,
    input logic led_supply,
    input logic led_oper
);
    a_r2_masked: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !led_oper |-> !(led_dclk_ok | led_cal | led_ovr_i | led_ovr_q |
                        led_trig_armed | led_ext_ctl | led_supply));

    a_r1_oper_rise: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $past(rst_n) && $rose(led_oper) |-> $past(ref_lock_in, 2));

    a_r1_oper_fall: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $past(rst_n) && $fell(led_oper) |-> !$past(ref_lock_in, 2));

    a_r4_cal_rise: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(led_cal) && $past(led_oper) |-> $past(cal_run_in, 3));

    a_r6_cal_no_early_drop: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $fell(led_cal) && led_oper && $past(led_oper) |-> !$past(cal_run_in, 3));

    a_r5_ovr_i_own_pin: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(led_ovr_i) && $past(led_oper) |-> $past(ovr_i_in, 3));

    a_r5_ovr_q_own_pin: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(led_ovr_q) && $past(led_oper) |-> $past(ovr_q_in, 3));

    a_r7_trig_follows: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(led_trig_armed) && $past(led_oper) |-> $past(hw_trig_en_in, 2));
endmodule

bind board_status_monitor board_status_monitor_sva u_sva (
    .clk_ref        (clk_ref),
    .rst_n          (rst_n),
    .ref_lock_in    (ref_lock_in),
    .cal_run_in     (cal_run_in),
    .ovr_i_in       (ovr_i_in),
    .ovr_q_in       (ovr_q_in),
    .hw_trig_en_in  (hw_trig_en_in),
    .led_dclk_ok    (led_dclk_ok),
    .led_cal        (led_cal),
    .led_ovr_i      (led_ovr_i),
    .led_ovr_q      (led_ovr_q),
    .led_trig_armed (led_trig_armed),
    .led_ext_ctl    (led_ext_ctl),
    .led_supply     (led_supply),
    .led_oper       (led_oper)
);

// File: tb/board_status_monitor_bench.sv
// Bench: behavioural per-cycle model (sampled-pin queue plus integer stretch counts).
module board_status_monitor_bench;
    localparam int STR = 20;
    localparam int WIN = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic dci = 1'b0, dcq = 1'b0, run_i = 1'b1, run_q = 1'b1;
    logic lock = 1'b0, cal = 1'b0, ovi = 1'b0, ovq = 1'b0;
    logic trg = 1'b0, xc = 1'b0, pw = 1'b0;
    logic l_dclk, l_cal, l_ovi, l_ovq, l_trg, l_xc, l_pw, l_oper;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    board_status_monitor #(.STRETCH_CYCLES(STR), .WINDOW_CYCLES(WIN)) u_board_status_monitor (
        .clk_ref(clk), .rst_n(rst_n), .data_clk_i(dci), .data_clk_q(dcq),
        .ref_lock_in(lock), .cal_run_in(cal), .ovr_i_in(ovi), .ovr_q_in(ovq),
        .hw_trig_en_in(trg), .ext_ctl_in(xc), .supply_ok_in(pw),
        .led_dclk_ok(l_dclk), .led_cal(l_cal), .led_ovr_i(l_ovi), .led_ovr_q(l_ovq),
        .led_trig_armed(l_trg), .led_ext_ctl(l_xc), .led_supply(l_pw), .led_oper(l_oper)
    );

    always #2 clk = ~clk;                    // 250 MHz reference
    initial begin #1;  forever begin #6;  if (run_i) dci = ~dci; end end
    initial begin #3;  forever begin #10; if (run_q) dcq = ~dcq; end end

    task automatic chk(string req, string nm, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, nm, act, exp, $time);
        end
    endtask

    // Reference model state.
    logic [6:0] hist[$];
    int   cnt [3];
    logic [6:0] s2, s2o;
    logic e_oper, e_cal, e_ovi, e_ovq, e_trg, e_xc, e_pw;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            for (int k = 0; k < 3; k++) cnt[k] = 0;
        end else begin
            hist.push_back({pw, xc, trg, ovq, ovi, cal, lock});
            if (hist.size() > 3) void'(hist.pop_front());
            s2o = (hist.size() >= 3) ? hist[0] : 7'd0;
            for (int k = 0; k < 3; k++) begin
                if (s2o[1+k]) cnt[k] = STR;
                else if (cnt[k] > 0) cnt[k] = cnt[k] - 1;
            end
        end
        s2 = (hist.size() >= 2) ? hist[hist.size()-2] : 7'd0;
        e_oper = s2[0];
        e_cal  = (cnt[0] > 0) && e_oper;
        e_ovi  = (cnt[1] > 0) && e_oper;
        e_ovq  = (cnt[2] > 0) && e_oper;
        e_trg  = s2[4] & e_oper;
        e_xc   = s2[5] & e_oper;
        e_pw   = s2[6] & e_oper;
        #1;
        chk("R1", "oper",   l_oper, e_oper);
        chk("R4", "cal",    l_cal,  e_cal);
        chk("R5", "ovr_i",  l_ovi,  e_ovi);
        chk("R6", "ovr_q",  l_ovq,  e_ovq);
        chk("R7", "trig",   l_trg,  e_trg);
        chk("R8", "extctl", l_xc,   e_xc);
        chk("R8", "supply", l_pw,   e_pw);
        if (!e_oper) chk("R2", "dclk_ok masked", l_dclk, 1'b0);
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        // R9: reset with lock already high keeps every lamp dark.
        lock = 1'b1; trg = 1'b1; pw = 1'b1;
        cyc(6);
        chk("R9", "all lamps in reset",
            l_dclk | l_cal | l_ovi | l_ovq | l_trg | l_xc | l_pw | l_oper, 1'b0);
        trg = 1'b0; pw = 1'b0;
        rst_n = 1'b1;
        cyc(60);
        chk("R1", "oper after lock", l_oper, 1'b1);
        chk("R3", "both clocks running", l_dclk, 1'b1);

        // R4: single calibration pulse.
        cal = 1'b1; cyc(1); cal = 1'b0; cyc(30);
        // R5: independent over-range pulses.
        ovi = 1'b1; cyc(1); ovi = 1'b0; cyc(5);
        ovq = 1'b1; cyc(1); ovq = 1'b0; cyc(30);
        // R6: retrigger landing on the last lit cycle.
        ovi = 1'b1; cyc(1); ovi = 1'b0; cyc(18);
        ovi = 1'b1; cyc(1); ovi = 1'b0; cyc(45);
        // R6: held-high event keeps reloading.
        cal = 1'b1; cyc(10); cal = 1'b0; cyc(40);

        // R7 and R8: level lamps.
        trg = 1'b1; cyc(10);
        xc = 1'b1; pw = 1'b1; cyc(10);
        ovq = 1'b1; cyc(1); ovq = 1'b0; cyc(30);
        chk("R7", "trig armed held", l_trg, 1'b1);
        trg = 1'b0; xc = 1'b0; cyc(10);

        // R3: each data clock stops and restarts.
        run_q = 1'b0; cyc(60);
        chk("R3", "q clock stopped", l_dclk, 1'b0);
        run_q = 1'b1; cyc(30);
        chk("R3", "q clock restarted", l_dclk, 1'b1);
        run_i = 1'b0; cyc(60);
        chk("R3", "i clock stopped", l_dclk, 1'b0);
        run_i = 1'b1; cyc(30);
        chk("R3", "i clock restarted", l_dclk, 1'b1);

        // R2: lock lost during a stretch; lamps masked, then return.
        ovq = 1'b1; cyc(1); ovq = 1'b0; cyc(5);
        lock = 1'b0; cyc(10);
        chk("R2", "ovr_q masked", l_ovq, 1'b0);
        lock = 1'b1; cyc(30);
        // R2: lock drop lands on the first cycle of a new stretch.
        cal = 1'b1; lock = 1'b0; cyc(1); cal = 1'b0; cyc(8);
        lock = 1'b1; cyc(40);

        // R9: reset mid-stretch clears everything.
        trg = 1'b1;
        cal = 1'b1; cyc(1); cal = 1'b0; cyc(3);
        rst_n = 1'b0; cyc(3);
        chk("R9", "cal cleared by reset", l_cal, 1'b0);
        chk("R9", "oper cleared by reset", l_oper, 1'b0);
        rst_n = 1'b1; cyc(60);
        chk("R9", "no stale stretch", l_cal, 1'b0);
        chk("R3", "clock ok after reset", l_dclk, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule